// File: doc/BRIEF.md
# Dominant Hold Timeout Guard

This block sits between a controller's active-low transmit line and the enable of a single-wire bus driver. While the transmit line is low the driver is asked to put the bus in its dominant state, and while it is high the bus is left recessive. A stuck-low transmit line would otherwise hold the shared wire dominant and silence every other node. The guard counts timebase ticks during each continuous low period. Once the count reaches a fixed limit, it cuts the driver enable for the rest of that low period.

The fault is cleared by the transmit line alone. As soon as the line is high, the enable and the timeout flag fall combinationally. The tick counter is cleared at the next clock edge, so the following low period starts a fresh count and has no recovery wait. A separate lockout input, driven by supply or thermal protection, also blocks the enable. It does not disturb the count. All pins are plain level signals with no handshake. The integrator ties an unused transmit input high so that the default is recessive.

Top module: `dom_guard`

## Requirements
- R1: While `tx_n` is 1 (recessive request), `drv_en` and `timed_out` are both 0 in the same cycle, whatever the count was.
- R2: While `tx_n` is 0, `lockout` is 0 and fewer than TIMEOUT_TICKS ticks have been counted, `drv_en` is 1 in the same cycle.
- R3: Every rising clock edge that sees `tx_n` = 0 and `tick` = 1 adds one to the count. Right after the edge that brings the count to TIMEOUT_TICKS, `timed_out` is 1 and `drv_en` is 0.
- R4: The count saturates at TIMEOUT_TICKS and never wraps. Once timed out, the block stays blocked (`timed_out` = 1, `drv_en` = 0) for as long as `tx_n` stays 0, however many further ticks arrive.
- R5: Any rising edge that sees `tx_n` = 1 clears the count. A single high cycle between two low periods therefore restores `drv_en` = 1, and the new low period needs a full TIMEOUT_TICKS ticks to time out.
- R6: `lockout` = 1 forces `drv_en` to 0. It does not pause or clear the count, and it does not mask `timed_out`.
- R7: While `rst_n` is 0, the count is held at 0 and both outputs are 0.
- R8: Ticks that arrive while `tx_n` is 1 are not counted, and a low period without ticks never times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_n | input | 1 | Transmit data, 0 = dominant request |
| tick | input | 1 | Timebase pulse, one clock wide, counted while dominant is requested |
| lockout | input | 1 | Protection lockout, 1 = driver must be off |
| drv_en | output | 1 | Bus driver enable |
| timed_out | output | 1 | 1 while a low period has exceeded the timeout |

## Verification
On every cycle, the in-line assertions check the following: a recessive request and an active lockout each keep the enable off, a timed-out state never drives, the count never passes its limit, a saturated count holds while the request stays low, a high input clears the count, and each counted tick adds exactly one. Only the bench scenarios can show the edge at which the timeout lands for a given tick pattern. They also show that a one-cycle release restores driving at once, that ticks during recessive periods leave no trace, and that a lockout running across the limit still lets the flag rise on schedule.

// File: rtl/dg_pkg.sv
package dg_pkg;

  typedef enum logic [1:0] {
    DG_RECESSIVE = 2'd0,
    DG_DRIVE     = 2'd1,
    DG_BLOCKED   = 2'd2
  } dg_state_e;

  function automatic int unsigned dg_cnt_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/dg_dwell_counter.sv
module dg_dwell_counter #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dom_req,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CW = dg_pkg::dg_cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          sat;

  assign sat     = (cnt == LIM_C);
  assign expired = sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!dom_req) begin
      cnt <= '0;
    end else if (tick && !sat) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_C);

  p_hold_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && dom_req) |=> sat);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_req |=> (cnt == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_req && tick && !sat) |=> (cnt == $past(cnt) + 1'b1));

  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_req && !tick) |=> $stable(cnt));

endmodule

// File: rtl/dg_gate.sv
module dg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dom_req,
  input  logic expired,
  input  logic lockout,
  output logic drv_en,
  output logic timed_out
);
  import dg_pkg::*;

  dg_state_e state;

  always_comb begin
    if (!rst_n || !dom_req) begin
      state = DG_RECESSIVE;
    end else if (expired) begin
      state = DG_BLOCKED;
    end else begin
      state = DG_DRIVE;
    end
  end

  assign drv_en    = (state == DG_DRIVE) && !lockout;
  assign timed_out = (state == DG_BLOCKED);

  p_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_req |-> (!drv_en && !timed_out));

  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !drv_en);

  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> !drv_en);

  p_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_req && !expired && !lockout) |-> drv_en);

endmodule

// File: rtl/dom_guard.sv
module dom_guard #(
  parameter int unsigned TIMEOUT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_n,
  input  logic tick,
  input  logic lockout,
  output logic drv_en,
  output logic timed_out
);
  logic dom_req;
  logic expired;

  assign dom_req = ~tx_n;

  dg_dwell_counter #(
    .LIMIT(TIMEOUT_TICKS)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .dom_req(dom_req),
    .tick   (tick),
    .expired(expired)
  );

  dg_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .dom_req  (dom_req),
    .expired  (expired),
    .lockout  (lockout),
    .drv_en   (drv_en),
    .timed_out(timed_out)
  );

  initial begin
    if (TIMEOUT_TICKS < 1) $error("TIMEOUT_TICKS must be at least 1");
  end

endmodule

// File: tb/dom_guard_tb.sv
module dom_guard_tb;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_n = 1'b1;
  logic tick = 1'b0;
  logic lockout = 1'b0;
  logic drv_en, timed_out;

  int checks = 0;
  int failures = 0;
  int mcnt = 0;

  always #4 clk = ~clk;

  dom_guard #(.TIMEOUT_TICKS(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_n(tx_n), .tick(tick),
    .lockout(lockout), .drv_en(drv_en), .timed_out(timed_out)
  );

  // Behavioural reference: count of ticks in the current low period
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt <= 0;
    else if (tx_n) mcnt <= 0;
    else if (tick && mcnt < LIM) mcnt <= mcnt + 1;
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    #3;
    begin
      logic ed, et;
      string tag;
      ed = rst_n && !tx_n && !lockout && (mcnt < LIM);
      et = rst_n && !tx_n && (mcnt == LIM);
      if (!rst_n) tag = "R7";
      else if (tx_n) tag = "R1";
      else if (mcnt == LIM) tag = "R4";
      else if (lockout) tag = "R6";
      else tag = "R2";
      chk(tag, drv_en, ed, "drv_en");
      chk(tag, timed_out, et, "timed_out");
    end
  end

  task automatic step(input logic t, input logic lk, input logic tk);
    @(negedge clk);
    tx_n = t; lockout = lk; tick = tk;
  endtask

  task automatic run(input int n, input logic t, input logic lk, input int period);
    for (int i = 0; i < n; i++) step(t, lk, (period > 0) && (i % period == 0));
  endtask

  task automatic finish_up;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R7: reset holds outputs low even with a dominant request
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    #3 chk("R7", drv_en, 1'b0, "drv_en in reset");
    step(1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    run(3, 1'b1, 1'b0, 0);

    // R2: short dominant bursts below the limit
    for (int k = 0; k < 4; k++) begin
      run(LIM + 2, 1'b0, 1'b0, 2);
      run(2, 1'b1, 1'b0, 1);
    end

    // R3: exact timeout edge with a tick every cycle
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < LIM; i++) step(1'b0, 1'b0, 1'b1);
    #3 chk("R3", timed_out, 1'b0, "one tick before limit");
    chk("R3", drv_en, 1'b1, "one tick before limit");
    step(1'b0, 1'b0, 1'b0);
    #3 chk("R3", timed_out, 1'b1, "at limit");
    chk("R3", drv_en, 1'b0, "at limit");

    // R4: long stuck-low, many ticks, no wrap
    run(60, 1'b0, 1'b0, 1);
    #3 chk("R4", timed_out, 1'b1, "still blocked");
    chk("R4", drv_en, 1'b0, "still blocked");

    // R1/R5: one high cycle releases at once and restarts the count
    step(1'b1, 1'b0, 1'b1);
    #3 chk("R1", timed_out, 1'b0, "release same cycle");
    chk("R1", drv_en, 1'b0, "release same cycle");
    step(1'b0, 1'b0, 1'b1);
    #3 chk("R5", drv_en, 1'b1, "fresh low period");
    run(LIM - 1, 1'b0, 1'b0, 1);
    #3 chk("R5", timed_out, 1'b0, "count restarted");

    // R6: lockout across the limit; counting continues
    step(1'b1, 1'b0, 1'b0);
    run(3, 1'b0, 1'b1, 1);
    #3 chk("R6", drv_en, 1'b0, "lockout blocks");
    run(LIM, 1'b0, 1'b1, 1);
    #3 chk("R6", timed_out, 1'b1, "flag under lockout");
    run(4, 1'b0, 1'b0, 1);
    #3 chk("R6", drv_en, 1'b0, "still timed out after lockout drops");

    // R8: ticks while recessive, then a low period without ticks
    run(40, 1'b1, 1'b0, 1);
    run(50, 1'b0, 1'b0, 0);
    #3 chk("R8", drv_en, 1'b1, "no ticks no timeout");
    chk("R8", timed_out, 1'b0, "no ticks no timeout");

    // Sparse ticks, timeout reached slowly
    step(1'b1, 1'b0, 1'b0);
    run(LIM * 5 + 3, 1'b0, 1'b0, 5);
    run(5, 1'b1, 1'b0, 3);
    run(10, 1'b0, 1'b1, 0);
    run(4, 1'b1, 1'b0, 0);
    @(negedge clk);
    #5;
    finish_up();
  end

endmodule